// File: doc/BRIEF.md
# Flash Command Interpreter

This block is the device-side command decoder of a byte-wide electrically erasable memory. A host drives an asynchronous strobe bus made of active-low chip enable, output enable and write enable, an 18-bit address and an 8-bit data byte. The block samples the strobes on its own clock. It turns command bytes written on that bus into operating modes: array read, identifier read, erase set-up and erase, erase verify, program set-up and program, program verify, and a two-write reset. It holds a small array model and a stop timer. Program and erase each take two writes, which makes an accidental change unlikely.

A write is a low pulse on write enable while chip enable is low. The address is captured on the pulse's falling edge and the data on its rising edge, and the command takes effect on the rising edge. Writes are accepted only while the programming-voltage flag is high and the low-supply lockout flag is low. A program or erase runs from the rising edge of the write that starts it until the rising edge of the next write, or until the stop timer runs out. In the second case the block goes inactive and keeps its outputs off until a new command arrives. The bus is strobe-driven and has no data stream, so there is no valid/ready pair and no back-pressure. A read holds chip enable and output enable low, and the result appears three clocks after the strobes settle: two synchroniser stages and one output register.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the mode is array read and every array byte reads FFh. In read mode a read returns the byte at the low `ARR_AW` address bits. Read mode stays selected until another valid command is written.
- R2: Writing 90h selects identifier mode. A read there at address 0 returns 89h, at address 1 returns BDh, and at any other address returns 00h.
- R3: Writing 20h and then 20h again sets every array byte to FFh and raises `busy` from the second write's rising edge. The next write ends the erase and drops `busy`.
- R4: Writing A0h selects erase verify. Reads then return the byte at the address captured on that write's falling edge, whatever address is on the bus, until another command is written.
- R5: After 40h, the next write programs one byte. Its address comes from the falling edge and its data from the rising edge. The new value is the old value AND the data, and `busy` rises on that rising edge.
- R6: Writing C0h ends programming and selects program verify. Reads then return the most recently programmed byte, whatever address is on the bus.
- R7: Two consecutive FFh writes return the block to read mode. After a 40h or 20h set-up they abort without changing any array byte.
- R8: A write has no effect while `hv_ok` is low or `lockout` is high.
- R9: `busy` is high exactly while a program or erase runs. If `PROG_TICKS` or `ERASE_TICKS` clocks pass with no write, the operation stops, `busy` falls, and the block is inactive (outputs off) until the next command.
- R10: `dq_oe` is high only while chip enable and output enable are low, write enable is high, and no operation is running or stopped. `dq_out` reads 00h whenever `dq_oe` is low.
- R11: A command byte outside 00h, 20h, 40h, 90h, A0h, C0h and FFh leaves the mode unchanged, except in a running operation or a program set-up.
- R12: A write-enable pulse while chip enable is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| addr | input | 18 | Bus address |
| dq_in | input | 8 | Data byte written by the host |
| hv_ok | input | 1 | High programming voltage is present |
| lockout | input | 1 | Supply is below the write lockout threshold |
| dq_out | output | 8 | Read data |
| dq_oe | output | 1 | Data output enable; low means high impedance |
| busy | output | 1 | Program or erase running |

## Verification
The bench programs one byte twice and expects the bitwise AND. A design that overwrites instead of clearing bits returns the second byte alone. It aborts both set-ups with two FFh writes and then reads the untouched byte. A design that starts the operation on the first FFh corrupts that byte or leaves `busy` high. It checks that erase verify uses the address captured on the A0h write and ignores the live bus, and that a stopped-timer state keeps the outputs off until a command arrives. It also drops the programming voltage, raises lockout and pulses write enable with chip enable high. A design that leaks any of these writes leaves identifier mode.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    M_READ,
    M_IDENT,
    M_ERS_ARM,
    M_ERS_RUN,
    M_ERS_VFY,
    M_PRG_ARM,
    M_PRG_RUN,
    M_PRG_VFY,
    M_STOPPED
  } mode_t;

  localparam logic [7:0] OP_READ  = 8'h00;
  localparam logic [7:0] OP_IDENT = 8'h90;
  localparam logic [7:0] OP_ERASE = 8'h20;
  localparam logic [7:0] OP_EVFY  = 8'hA0;
  localparam logic [7:0] OP_PROG  = 8'h40;
  localparam logic [7:0] OP_PVFY  = 8'hC0;
  localparam logic [7:0] OP_RESET = 8'hFF;
  localparam logic [7:0] ID_MAKER = 8'h89;
  localparam logic [7:0] ID_PART  = 8'hBD;

endpackage

// File: rtl/fc_sync.sv
module fc_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= '1;
      stage2 <= '1;
    end else begin
      stage1 <= din;
      stage2 <= stage1;
    end
  end

  assign dout = stage2;
endmodule

// File: rtl/fc_stop_timer.sv
module fc_stop_timer #(
  parameter int PROG_TICKS  = 40,
  parameter int ERASE_TICKS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_prog,
  input  logic start_erase,
  input  logic cancel,
  output logic running,
  output logic done
);
  localparam int MAXT = (PROG_TICKS > ERASE_TICKS) ? PROG_TICKS : ERASE_TICKS;
  localparam int CW   = $clog2(MAXT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (start_prog) begin
      cnt     <= CW'(PROG_TICKS - 1);
      running <= 1'b1;
    end else if (start_erase) begin
      cnt     <= CW'(ERASE_TICKS - 1);
      running <= 1'b1;
    end else if (cancel) begin
      running <= 1'b0;
    end else if (running) begin
      if (cnt == '0) running <= 1'b0;
      else           cnt     <= cnt - 1'b1;
    end
  end

  assign done = running && (cnt == '0);
endmodule

// File: rtl/fc_array.sv
module fc_array #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          erase_all,
  input  logic          prog_en,
  input  logic [AW-1:0] prog_addr,
  input  logic [DW-1:0] prog_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n || erase_all) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
    end else if (prog_en) begin
      cells[prog_addr] <= cells[prog_addr] & prog_data;
    end
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/fc_cmd_fsm.sv
module fc_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_lead,
  input  logic          wr_trail,
  input  logic [AW-1:0] addr_in,
  input  logic [7:0]    data_in,
  input  logic          tmr_done,
  output mode_t         mode,
  output logic          start_prog,
  output logic          start_erase,
  output logic          cancel,
  output logic [AW-1:0] lat_addr,
  output logic [AW-1:0] vfy_addr,
  output logic [AW-1:0] last_addr
);
  mode_t nxt;
  logic  rst_pend, nxt_pend, cap_vfy, running;

  function automatic mode_t decode(input logic [7:0] op, input mode_t cur);
    case (op)
      OP_READ:  return M_READ;
      OP_IDENT: return M_IDENT;
      OP_ERASE: return M_ERS_ARM;
      OP_PROG:  return M_PRG_ARM;
      OP_EVFY:  return M_ERS_VFY;
      OP_PVFY:  return M_PRG_VFY;
      default:  return (cur == M_PRG_RUN || cur == M_ERS_RUN) ? M_STOPPED : cur;
    endcase
  endfunction

  assign running = (mode == M_PRG_RUN) || (mode == M_ERS_RUN);

  always_comb begin
    nxt         = mode;
    nxt_pend    = rst_pend;
    start_prog  = 1'b0;
    start_erase = 1'b0;
    cap_vfy     = 1'b0;
    if (wr_trail) begin
      nxt_pend = 1'b0;
      if (data_in == OP_RESET) begin
        if (rst_pend)     nxt = M_READ;
        else begin
          nxt_pend = 1'b1;
          if (running) nxt = M_STOPPED;
        end
      end else if (mode == M_PRG_ARM) begin
        start_prog = 1'b1;
        nxt        = M_PRG_RUN;
      end else if (mode == M_ERS_ARM && data_in == OP_ERASE) begin
        start_erase = 1'b1;
        nxt         = M_ERS_RUN;
      end else begin
        nxt     = decode(data_in, mode);
        cap_vfy = (data_in == OP_EVFY);
      end
    end else if (tmr_done && running) begin
      nxt = M_STOPPED;
    end
  end

  assign cancel = wr_trail && running;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode      <= M_READ;
      rst_pend  <= 1'b0;
      lat_addr  <= '0;
      vfy_addr  <= '0;
      last_addr <= '0;
    end else begin
      mode     <= nxt;
      rst_pend <= nxt_pend;
      if (wr_lead)    lat_addr  <= addr_in;
      if (cap_vfy)    vfy_addr  <= lat_addr;
      if (start_prog) last_addr <= lat_addr;
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int DATA_W      = 8,
  parameter int ARR_AW      = 8,
  parameter int PROG_TICKS  = 40,
  parameter int ERASE_TICKS = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  input  logic              hv_ok,
  input  logic              lockout,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              busy
);
  localparam int NSTB = 3;

  logic [NSTB-1:0] stb_s;
  logic            ce_s, oe_s, we_s, we_d;
  logic            we_rise, we_fall, wr_ok, wr_lead, wr_trail;
  logic            start_prog, start_erase, cancel, tmr_done;
  logic [ARR_AW-1:0] lat_addr, vfy_addr, last_addr, rd_idx;
  logic [DATA_W-1:0] arr_byte, rd_byte;
  logic            out_allowed;
  mode_t           mode;

  fc_sync #(.W(NSTB)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({we_n, oe_n, ce_n}), .dout(stb_s)
  );

  assign ce_s = stb_s[0];
  assign oe_s = stb_s[1];
  assign we_s = stb_s[2];

  always_ff @(posedge clk) begin
    if (!rst_n) we_d <= 1'b1;
    else        we_d <= we_s;
  end

  assign we_rise  = we_s & ~we_d;
  assign we_fall  = ~we_s & we_d;
  assign wr_ok    = hv_ok & ~lockout;
  assign wr_lead  = we_fall & ~ce_s & wr_ok;
  assign wr_trail = we_rise & ~ce_s & wr_ok;

  fc_cmd_fsm #(.AW(ARR_AW)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .wr_lead(wr_lead), .wr_trail(wr_trail),
    .addr_in(addr[ARR_AW-1:0]), .data_in(dq_in[7:0]),
    .tmr_done(tmr_done), .mode(mode),
    .start_prog(start_prog), .start_erase(start_erase), .cancel(cancel),
    .lat_addr(lat_addr), .vfy_addr(vfy_addr), .last_addr(last_addr)
  );

  fc_stop_timer #(.PROG_TICKS(PROG_TICKS), .ERASE_TICKS(ERASE_TICKS)) u_tmr (
    .clk(clk), .rst_n(rst_n),
    .start_prog(start_prog), .start_erase(start_erase), .cancel(cancel),
    .running(busy), .done(tmr_done)
  );

  fc_array #(.AW(ARR_AW), .DW(DATA_W)) u_arr (
    .clk(clk), .rst_n(rst_n),
    .erase_all(start_erase), .prog_en(start_prog),
    .prog_addr(lat_addr), .prog_data(dq_in),
    .rd_addr(rd_idx), .rd_data(arr_byte)
  );

  always_comb begin
    case (mode)
      M_PRG_VFY: rd_idx = last_addr;
      M_ERS_VFY: rd_idx = vfy_addr;
      default:   rd_idx = addr[ARR_AW-1:0];
    endcase
  end

  always_comb begin
    if (mode == M_IDENT) begin
      if (addr == ADDR_W'(0))      rd_byte = DATA_W'(ID_MAKER);
      else if (addr == ADDR_W'(1)) rd_byte = DATA_W'(ID_PART);
      else                         rd_byte = '0;
    end else begin
      rd_byte = arr_byte;
    end
  end

  assign out_allowed = ~ce_s & ~oe_s & we_s &
                       (mode != M_PRG_RUN) & (mode != M_ERS_RUN) & (mode != M_STOPPED);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dq_oe  <= 1'b0;
      dq_out <= '0;
    end else begin
      dq_oe  <= out_allowed;
      dq_out <= out_allowed ? rd_byte : '0;
    end
  end
endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk
  import flash_cmd_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input mode_t mode,
  input logic  busy,
  input logic  dq_oe,
  input logic  we_rise,
  input logic  ce_s,
  input logic  hv_ok,
  input logic  lockout,
  input logic  tmr_done,
  input logic  wr_trail
);
  assert_busy_tracks_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (mode == M_PRG_RUN || mode == M_ERS_RUN));

  assert_stop_goes_inactive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_done && !wr_trail) |=> (mode == M_STOPPED));

  assert_gated_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (we_rise && !ce_s && (!hv_ok || lockout) && !tmr_done) |=> $stable(mode));

  assert_mode_moves_on_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode) |-> $past(wr_trail || tmr_done));

  assert_no_drive_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !$past(busy));

  assert_busy_from_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(mode) == M_PRG_ARM || $past(mode) == M_ERS_ARM));
endmodule

bind flash_cmd_ctrl flash_cmd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .busy(busy), .dq_oe(dq_oe),
  .we_rise(we_rise), .ce_s(ce_s), .hv_ok(hv_ok), .lockout(lockout),
  .tmr_done(tmr_done), .wr_trail(wr_trail)
);

// File: tb/sim_flash_cmd_ctrl.sv
module sim_flash_cmd_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [17:0] addr = '0;
  logic [7:0]  dq_in = '0;
  logic        hv_ok = 1'b1, lockout = 1'b0;
  logic [7:0]  dq_out;
  logic        dq_oe, busy;

  int total = 0;
  int bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         want = 1'b0;

  always #10 clk = ~clk;

  flash_cmd_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .dq_in(dq_in), .hv_ok(hv_ok), .lockout(lockout),
    .dq_out(dq_out), .dq_oe(dq_oe), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // monitor: pops expected read bytes and compares against the bus
  always @(negedge clk) begin
    if (want) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(dq_oe === 1'b1, {t, " oe"}, int'(dq_oe), 1);
      chk(dq_out === e, t, int'(dq_out), int'(e));
      want = 1'b0;
    end
  end

  task automatic wr(input logic [17:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; dq_in = d; ce_n = 1'b0;
    repeat (2) @(negedge clk);
    we_n = 1'b0;
    repeat (4) @(negedge clk);
    we_n = 1'b1;
    repeat (4) @(negedge clk);
    ce_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wr_nce(input logic [17:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; dq_in = d; ce_n = 1'b1;
    repeat (2) @(negedge clk);
    we_n = 1'b0;
    repeat (4) @(negedge clk);
    we_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic rd(input logic [17:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    repeat (5) @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
    want = 1'b1;
    wait (want == 1'b0);
    oe_n = 1'b1; ce_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic hiz(input bit oe_low, input string t);
    @(negedge clk);
    ce_n = 1'b0; oe_n = !oe_low;
    repeat (5) @(negedge clk);
    chk(dq_oe === 1'b0, t, int'(dq_oe), 0);
    chk(dq_out === 8'h00, {t, " data"}, int'(dq_out), 0);
    oe_n = 1'b1; ce_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dq_oe === 1'b0, "R10 reset oe", int'(dq_oe), 0);
    chk(busy === 1'b0, "R1 reset busy", int'(busy), 0);
    rd(18'd3, 8'hFF, "R1 erased default read");

    // program byte 3, verify, then AND behaviour
    wr(0, 8'h40); wr(18'd3, 8'hA5);
    chk(busy === 1'b1, "R5 busy after program", int'(busy), 1);
    wr(0, 8'hC0);
    chk(busy === 1'b0, "R3 program ended by write", int'(busy), 0);
    rd(18'd77, 8'hA5, "R6 program verify ignores bus address");
    wr(0, 8'h00);
    rd(18'd3, 8'hA5, "R1 read programmed byte");
    wr(0, 8'h40); wr(18'd3, 8'h3C); wr(0, 8'hC0);
    rd(18'd3, 8'h24, "R5 program ANDs old and new");
    hiz(1'b0, "R10 oe high no drive");

    // identifier and ignored writes
    wr(0, 8'h90);
    rd(18'd0, 8'h89, "R2 maker id");
    rd(18'd1, 8'hBD, "R2 part id");
    rd(18'd2, 8'h00, "R2 other id address");
    wr(0, 8'h55);
    rd(18'd1, 8'hBD, "R11 undefined command ignored");
    wr_nce(0, 8'h00);
    rd(18'd0, 8'h89, "R12 write with ce high ignored");
    hv_ok = 1'b0; wr(0, 8'h00); hv_ok = 1'b1;
    rd(18'd0, 8'h89, "R8 no programming voltage");
    lockout = 1'b1; wr(0, 8'h00); lockout = 1'b0;
    rd(18'd0, 8'h89, "R8 lockout");

    // reset aborts
    wr(0, 8'h00);
    wr(0, 8'h40); wr(18'd3, 8'hFF); wr(18'd3, 8'hFF);
    chk(busy === 1'b0, "R7 no program after reset", int'(busy), 0);
    rd(18'd3, 8'h24, "R7 program abort keeps byte");
    wr(0, 8'h20); wr(0, 8'hFF); wr(0, 8'hFF);
    chk(busy === 1'b0, "R7 no erase after reset", int'(busy), 0);
    rd(18'd3, 8'h24, "R7 erase abort keeps byte");

    // erase and erase verify
    wr(0, 8'h20); wr(0, 8'h20);
    chk(busy === 1'b1, "R3 busy during erase", int'(busy), 1);
    wr(18'd3, 8'hA0);
    chk(busy === 1'b0, "R3 erase ended by write", int'(busy), 0);
    rd(18'd50, 8'hFF, "R3 byte erased");
    wr(0, 8'h40); wr(18'd12, 8'h00); wr(0, 8'hC0);
    wr(18'd12, 8'hA0);
    rd(18'd0, 8'h00, "R4 verify captured address");
    rd(18'd200, 8'h00, "R4 verify persists");
    wr(18'd13, 8'hA0);
    rd(18'd12, 8'hFF, "R4 verify new address");

    // stop timer expiry
    wr(0, 8'h40); wr(18'd20, 8'h77);
    repeat (60) @(negedge clk);
    chk(busy === 1'b0, "R9 program timer expiry", int'(busy), 0);
    hiz(1'b1, "R9 inactive after program stop");
    wr(0, 8'h00);
    rd(18'd20, 8'h77, "R9 read after inactive");
    wr(0, 8'h20); wr(0, 8'h20);
    repeat (120) @(negedge clk);
    chk(busy === 1'b0, "R9 erase timer expiry", int'(busy), 0);
    hiz(1'b1, "R9 inactive after erase stop");
    wr(0, 8'h00);
    rd(18'd20, 8'hFF, "R3 erase completed before stop");

    summary();
  end
endmodule